// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home side of a directory-based cache coherence scheme for a shared-memory machine made of eight node clusters. Each memory line held at this home has one directory entry. The entry records which cluster, if any, owns the line. It also keeps a presence vector with one bit per cluster. Requests arrive in order on a request channel: shared read, exclusive read, upgrade to exclusive and owner writeback. For every request the controller makes one directory lookup and decides what to do. It either answers from its memory array, forwards the request to the owning cluster, or grants ownership. In the same access it writes the entry's final value. It never refuses a request and never asks for a retry.

An owning cluster may keep a dirty line while other clusters share it. In that case every later request goes to the owner, and memory is not refreshed until the owner writes the line back. Each request produces one primary message, which is the reply, forward or grant. The primary message is followed by zero or more invalidations, one per cluster. All of these leave on a single ordered output channel that uses valid/ready flow control. A new request is accepted in the same cycle that the last message of the previous one leaves, so the controller sustains one request per cycle.

Top module: `home_dir_ctrl`

## Requirements
- R1: An entry holds an owner code of OWN_W bits (0 = memory owns the line, k+1 = cluster k owns it) and a presence vector with one bit per cluster. After reset every entry has owner 0 and no presence bits, and every memory word is zero.
- R2: A read (request code 0) of a memory-owned line sends the memory word to the requester and sets the requester's presence bit. The reply is exclusive-clean (message code 1) if no other cluster's presence bit is set, and shared (message code 0) otherwise.
- R3: A read of a cache-owned line is forwarded (code 3) to the owner and carries the requester's number. The requester's presence bit is added and the owner keeps the line. Memory is not written.
- R4: An exclusive read (request code 1) of a memory-owned line sends the memory word to the requester as a modified reply (code 2).
- R5: An exclusive read of a line owned by another cluster is forwarded (code 4) to that owner.
- R6: An upgrade (request code 2) of a line owned by another cluster is forwarded (code 5) to the owner. An upgrade of a memory-owned line, and an upgrade or exclusive read by the current owner, gets a grant without data (code 6).
- R7: Exclusive reads and upgrades send an invalidation (code 7) to every cluster whose presence bit is set, except the requester and the old owner. The requester then becomes owner and is the only cluster left in the presence vector.
- R8: The primary message leaves first. The invalidations follow, one message per cluster, in ascending cluster number.
- R9: A writeback (request code 3) from the owner stores its data in memory, sets the owner code to 0, clears the writer's presence bit and returns an acknowledge (code 8).
- R10: A writeback from a cluster that is not the owner changes neither memory nor the entry, and is still acknowledged with code 8.
- R11: No request is refused or retried. All messages of one request leave before any message of the next request, in the order the requests were accepted. A request is only accepted while the output is idle or while the output is handing over its last pending message.
- R12: While a message is offered and not taken, it stays valid and all of its fields stay unchanged.
- R13: The data field is zero on every message except codes 0, 1 and 2.
- R14: During reset and in the first cycle after it, no message is offered and the request input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken this cycle |
| req_kind | input | 2 | 0 read, 1 exclusive read, 2 upgrade, 3 writeback |
| req_node | input | NODE_W (3) | Requesting cluster |
| req_line | input | LINE_W (4) | Line index at this home |
| req_wdata | input | DATA_W (32) | Writeback data |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The message is taken this cycle |
| msg_kind | output | 4 | Message code (see R2 to R9) |
| msg_dest | output | NODE_W (3) | Destination cluster |
| msg_src | output | NODE_W (3) | Cluster whose request caused the message |
| msg_line | output | LINE_W (4) | Line index |
| msg_data | output | DATA_W (32) | Memory word for data replies, else zero |

## Verification
The bench targets four situations. The first is dirty sharing: a controller that refreshed memory or reassigned the owner on a read would later reply with stale data or forward to the wrong cluster. The second is an upgrade from a sharer while a third cluster owns the line; a wrong invalidation mask would either invalidate the owner or skip a sharer. The third is a stale writeback from a former owner; if it were applied, a later read would see the wrong word, or the read would not be forwarded to the real owner. The fourth is a full fan-out to seven clusters under output backpressure with no gap between requests. An out-of-order invalidation walk, or a request accepted in the middle of a burst, would interleave the message streams and break the scoreboard's order.

// File: rtl/coh_pkg.sv
// Shared encodings for the home directory controller.
// Assumes request and message codes are fixed by the fabric and are not configurable.
package coh_pkg;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_RDX = 2'd1,
        REQ_UPG = 2'd2,
        REQ_WB  = 2'd3
    } req_e;

    typedef enum logic [3:0] {
        MSG_RPL_SHR = 4'd0,
        MSG_RPL_EXC = 4'd1,
        MSG_RPL_MOD = 4'd2,
        MSG_FWD_RD  = 4'd3,
        MSG_FWD_RDX = 4'd4,
        MSG_FWD_UPG = 4'd5,
        MSG_GRANT   = 4'd6,
        MSG_INVAL   = 4'd7,
        MSG_WB_ACK  = 4'd8
    } msg_e;

endpackage

// File: rtl/dir_store.sv
// Directory entries and the behavioural memory array for one home.
// Reads are combinational from registers; one line may be written per cycle.
// Assumes the write line equals the read line (single access per request).
module dir_store #(
    parameter int NODES  = 8,
    parameter int OWN_W  = 6,
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    output logic [OWN_W-1:0]  rd_owner,
    output logic [NODES-1:0]  rd_pres,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_we,
    input  logic [OWN_W-1:0]  wr_owner,
    input  logic [NODES-1:0]  wr_pres,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] wr_data
);

    logic [OWN_W-1:0]  owner_q [LINES];
    logic [NODES-1:0]  pres_q  [LINES];
    logic [DATA_W-1:0] mem_q   [LINES];

    // Look up the addressed line.
    assign rd_owner = owner_q[line];
    assign rd_pres  = pres_q[line];
    assign rd_data  = mem_q[line];

    // Clear everything on reset, then apply the single-line update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                owner_q[i] <= '0;
                pres_q[i]  <= '0;
                mem_q[i]   <= '0;
            end
        end else begin
            if (dir_we) begin
                owner_q[line] <= wr_owner;
                pres_q[line]  <= wr_pres;
            end
            if (mem_we) begin
                mem_q[line] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/coh_decide.sv
// Combinational protocol decision: from one directory entry and one request,
// produce the final entry, the memory write and the message plan
// (one primary message plus an invalidation mask).
// Assumes owner code 0 means memory and code k+1 means cluster k.
module coh_decide #(
    parameter int NODES  = 8,
    parameter int OWN_W  = 6,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  coh_pkg::req_e     kind,
    input  logic [NODE_W-1:0] node,
    input  logic [OWN_W-1:0]  owner,
    input  logic [NODES-1:0]  pres,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] wb_data,
    output logic [OWN_W-1:0]  new_owner,
    output logic [NODES-1:0]  new_pres,
    output logic              dir_we,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output coh_pkg::msg_e     p_kind,
    output logic [NODE_W-1:0] p_dest,
    output logic [DATA_W-1:0] p_data,
    output logic [NODES-1:0]  inv_mask
);

    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  own_bit;
    logic [NODE_W-1:0] own_node;
    logic [OWN_W-1:0]  req_code;
    logic              cached;
    logic              is_owner;

    // Decode the requester and the current owner.
    always_comb begin
        req_bit  = NODES'(1) << node;
        cached   = (owner != '0);
        own_node = NODE_W'(owner - OWN_W'(1));
        own_bit  = cached ? (NODES'(1) << own_node) : '0;
        req_code = OWN_W'(node) + OWN_W'(1);
        is_owner = cached && (own_node == node);
    end

    // Choose the entry update and the message plan for the request kind.
    always_comb begin
        new_owner = owner;
        new_pres  = pres;
        dir_we    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = wb_data;
        p_kind    = coh_pkg::MSG_WB_ACK;
        p_dest    = node;
        p_data    = '0;
        inv_mask  = '0;
        unique case (kind)
            coh_pkg::REQ_RD: begin
                dir_we   = 1'b1;
                new_pres = pres | req_bit;
                if (cached) begin
                    p_kind = coh_pkg::MSG_FWD_RD;
                    p_dest = own_node;
                end else begin
                    p_kind = ((pres & ~req_bit) == '0) ? coh_pkg::MSG_RPL_EXC
                                                       : coh_pkg::MSG_RPL_SHR;
                    p_data = mem_data;
                end
            end
            coh_pkg::REQ_RDX, coh_pkg::REQ_UPG: begin
                dir_we    = 1'b1;
                new_owner = req_code;
                new_pres  = req_bit;
                inv_mask  = pres & ~req_bit & ~own_bit;
                if (cached && !is_owner) begin
                    p_kind = (kind == coh_pkg::REQ_RDX) ? coh_pkg::MSG_FWD_RDX
                                                        : coh_pkg::MSG_FWD_UPG;
                    p_dest = own_node;
                end else if (kind == coh_pkg::REQ_RDX && !cached) begin
                    p_kind = coh_pkg::MSG_RPL_MOD;
                    p_data = mem_data;
                end else begin
                    p_kind = coh_pkg::MSG_GRANT;
                end
            end
            coh_pkg::REQ_WB: begin
                if (is_owner) begin
                    dir_we    = 1'b1;
                    mem_we    = 1'b1;
                    new_owner = '0;
                    new_pres  = pres & ~req_bit;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msg_seq.sv
// Output sequencer: holds one request's plan and emits the primary message,
// then one invalidation per marked cluster in ascending cluster order.
// Assumes load is asserted only when idle or when the last message is taken.
module msg_seq #(
    parameter int NODES  = 8,
    parameter int LINE_W = 4,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  coh_pkg::msg_e     l_kind,
    input  logic [NODE_W-1:0] l_dest,
    input  logic [NODE_W-1:0] l_src,
    input  logic [LINE_W-1:0] l_line,
    input  logic [DATA_W-1:0] l_data,
    input  logic [NODES-1:0]  l_inv,
    output logic              m_valid,
    input  logic              m_ready,
    output coh_pkg::msg_e     m_kind,
    output logic [NODE_W-1:0] m_dest,
    output logic [NODE_W-1:0] m_src,
    output logic [LINE_W-1:0] m_line,
    output logic [DATA_W-1:0] m_data,
    output logic              last_fire
);

    logic              prim_q;
    coh_pkg::msg_e     kind_q;
    logic [NODE_W-1:0] dest_q;
    logic [NODE_W-1:0] src_q;
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] data_q;
    logic [NODES-1:0]  inv_q;
    logic [NODE_W-1:0] low_idx;
    logic              fire;
    logic              is_last;

    // Find the lowest-numbered cluster still awaiting an invalidation.
    always_comb begin
        low_idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (inv_q[i]) low_idx = NODE_W'(i);
        end
    end

    // Present the primary message first, then the invalidation walk.
    always_comb begin
        m_valid   = prim_q || (inv_q != '0);
        m_kind    = prim_q ? kind_q : coh_pkg::MSG_INVAL;
        m_dest    = prim_q ? dest_q : low_idx;
        m_data    = prim_q ? data_q : '0;
        m_src     = src_q;
        m_line    = line_q;
        fire      = m_valid && m_ready;
        is_last   = prim_q ? (inv_q == '0) : ((inv_q & (inv_q - NODES'(1))) == '0);
        last_fire = fire && is_last;
    end

    // Load a new plan or retire the message just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= 1'b0;
            kind_q <= coh_pkg::MSG_WB_ACK;
            dest_q <= '0;
            src_q  <= '0;
            line_q <= '0;
            data_q <= '0;
            inv_q  <= '0;
        end else if (load) begin
            prim_q <= 1'b1;
            kind_q <= l_kind;
            dest_q <= l_dest;
            src_q  <= l_src;
            line_q <= l_line;
            data_q <= l_data;
            inv_q  <= l_inv;
        end else if (fire) begin
            if (prim_q) prim_q <= 1'b0;
            else        inv_q[low_idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/home_dir_ctrl.sv
// Home-node directory controller: one directory lookup and update per
// accepted request, with the resulting messages sent on one ordered channel.
// Assumes requests for this home arrive in order and are never refused.
module home_dir_ctrl #(
    parameter int NODES  = 8,
    parameter int OWN_W  = 6,
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [3:0]        msg_kind,
    output logic [NODE_W-1:0] msg_dest,
    output logic [NODE_W-1:0] msg_src,
    output logic [LINE_W-1:0] msg_line,
    output logic [DATA_W-1:0] msg_data
);

    logic [OWN_W-1:0]  cur_owner, nxt_owner;
    logic [NODES-1:0]  cur_pres, nxt_pres, inv_mask;
    logic [DATA_W-1:0] cur_data, mem_wdata, p_data;
    logic              dir_we, mem_we, accept, last_fire;
    coh_pkg::msg_e     p_kind, m_kind;
    logic [NODE_W-1:0] p_dest;

    // Take a request when the output is idle or finishing its last message.
    assign req_ready = !msg_valid || last_fire;
    assign accept    = req_valid && req_ready;
    assign msg_kind  = 4'(m_kind);

    dir_store #(
        .NODES(NODES), .OWN_W(OWN_W), .LINES(LINES), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .line(req_line),
        .rd_owner(cur_owner), .rd_pres(cur_pres), .rd_data(cur_data),
        .dir_we(dir_we && accept), .wr_owner(nxt_owner), .wr_pres(nxt_pres),
        .mem_we(mem_we && accept), .wr_data(mem_wdata)
    );

    coh_decide #(
        .NODES(NODES), .OWN_W(OWN_W), .DATA_W(DATA_W)
    ) u_decide (
        .kind(coh_pkg::req_e'(req_kind)), .node(req_node),
        .owner(cur_owner), .pres(cur_pres), .mem_data(cur_data), .wb_data(req_wdata),
        .new_owner(nxt_owner), .new_pres(nxt_pres), .dir_we(dir_we),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .p_kind(p_kind), .p_dest(p_dest), .p_data(p_data), .inv_mask(inv_mask)
    );

    msg_seq #(
        .NODES(NODES), .LINE_W(LINE_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .l_kind(p_kind), .l_dest(p_dest), .l_src(req_node), .l_line(req_line),
        .l_data(p_data), .l_inv(inv_mask),
        .m_valid(msg_valid), .m_ready(msg_ready), .m_kind(m_kind),
        .m_dest(msg_dest), .m_src(msg_src), .m_line(msg_line), .m_data(msg_data),
        .last_fire(last_fire)
    );

endmodule

// File: rtl/home_dir_chk.sv
// Protocol checker for the home directory controller, attached by bind.
// Watches only the port-level handshakes and message fields.
module home_dir_chk #(
    parameter int NODE_W = 3,
    parameter int LINE_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [3:0]        msg_kind,
    input logic [NODE_W-1:0] msg_dest,
    input logic [NODE_W-1:0] msg_src,
    input logic [LINE_W-1:0] msg_line,
    input logic [DATA_W-1:0] msg_data
);

    logic              prev_inv;
    logic [NODE_W-1:0] prev_dest;

    // Remember whether the last message taken was an invalidation, and where it went.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_inv  <= 1'b0;
            prev_dest <= '0;
        end else if (msg_valid && msg_ready) begin
            prev_inv  <= (msg_kind == 4'd7);
            prev_dest <= msg_dest;
        end
    end

    assert_reset_idle_R14: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && req_ready));

    assert_msg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest)
            && $stable(msg_src) && $stable(msg_line) && $stable(msg_data)));

    assert_inval_not_requester_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 4'd7) |-> (msg_dest != msg_src));

    assert_data_only_replies_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind > 4'd2) |-> (msg_data == '0));

    assert_inval_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && msg_kind == 4'd7 && prev_inv) |-> (msg_dest > prev_dest));

    assert_no_accept_midburst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && msg_valid) |-> msg_ready);

endmodule

bind home_dir_ctrl home_dir_chk #(
    .NODE_W(NODE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)
) u_home_dir_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_src(msg_src), .msg_line(msg_line), .msg_data(msg_data)
);

// File: tb/test_home_dir_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts messages from the requirements and
// queues them; the monitor compares each message taken from the design.
module test_home_dir_ctrl;

    localparam int NODES = 8, OWN_W = 6, LINES = 16, DATA_W = 32;
    localparam int NODE_W = 3, LINE_W = 4;
    localparam int ITEM_W = 4 + NODE_W + NODE_W + LINE_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [NODE_W-1:0] req_node = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [3:0]        msg_kind;
    logic [NODE_W-1:0] msg_dest, msg_src;
    logic [LINE_W-1:0] msg_line;
    logic [DATA_W-1:0] msg_data;

    int checks = 0;
    int errors = 0;
    bit bp_en  = 1'b0;
    bit done   = 1'b0;

    logic [ITEM_W-1:0] exp_q[$];
    string             tag_q[$];

    int               m_owner [LINES];
    logic [NODES-1:0] m_pres  [LINES];
    logic [DATA_W-1:0] m_mem  [LINES];

    always #10 clk = ~clk;

    home_dir_ctrl #(.NODES(NODES), .OWN_W(OWN_W), .LINES(LINES), .DATA_W(DATA_W)) i_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_node(req_node), .req_line(req_line), .req_wdata(req_wdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_src(msg_src), .msg_line(msg_line), .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int dest, input int src, input int line,
                        input logic [DATA_W-1:0] data, input string tag);
        exp_q.push_back({4'(kind), NODE_W'(dest), NODE_W'(src), LINE_W'(line), data});
        tag_q.push_back(tag);
    endtask

    // Predict messages and the new entry from the requirement rules.
    task automatic predict(input int kind, input int node, input int line,
                           input logic [DATA_W-1:0] wd, input string tag);
        logic [NODES-1:0] rb, ob;
        int own;
        own = m_owner[line];
        rb  = NODES'(1) << node;
        ob  = (own != 0) ? (NODES'(1) << (own - 1)) : '0;
        case (kind)
            0: begin
                if (own != 0) push(3, own - 1, node, line, '0, tag);
                else push(((m_pres[line] & ~rb) == '0) ? 1 : 0, node, node, line, m_mem[line], tag);
                m_pres[line] |= rb;
            end
            1, 2: begin
                if (own != 0 && own - 1 != node) push((kind == 1) ? 4 : 5, own - 1, node, line, '0, tag);
                else if (kind == 1 && own == 0) push(2, node, node, line, m_mem[line], tag);
                else push(6, node, node, line, '0, tag);
                for (int i = 0; i < NODES; i++)
                    if (m_pres[line][i] && !rb[i] && !ob[i]) push(7, i, node, line, '0, tag);
                m_owner[line] = node + 1;
                m_pres[line]  = rb;
            end
            default: begin
                if (own == node + 1) begin
                    m_mem[line]   = wd;
                    m_owner[line] = 0;
                    m_pres[line] &= ~rb;
                end
                push(8, node, node, line, '0, tag);
            end
        endcase
    endtask

    // Driver: called at a rising edge plus 2 ns, returns at the same phase.
    task automatic do_req(input int kind, input int node, input int line,
                          input logic [DATA_W-1:0] wd, input string tag);
        predict(kind, node, line, wd, tag);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_node  = NODE_W'(node);
        req_line  = LINE_W'(line);
        req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    // Monitor: compare every message taken against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected message", longint'(msg_kind), 0);
            end else begin
                logic [ITEM_W-1:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {msg_kind, msg_dest, msg_src, msg_line, msg_data};
                check(a == e, t, "message kind/dest/src/line/data", longint'(a), longint'(e));
            end
        end
    end

    // Output backpressure: ready low one cycle in three when enabled.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            msg_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    task automatic finish_up;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_owner[i] = 0; m_pres[i] = '0; m_mem[i] = '0;
        end
        repeat (3) @(posedge clk);
        #2;
        check(!msg_valid, "R14", "msg_valid in reset", msg_valid, 0);
        check(req_ready, "R14", "req_ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(!msg_valid, "R14", "msg_valid after reset", msg_valid, 0);

        // Memory-owned reads: exclusive-clean first, then shared (R1, R2).
        do_req(0, 2, 3, '0, "R1");
        do_req(0, 5, 3, '0, "R2");
        // Exclusive read from memory with invalidations (R4, R7, R8).
        do_req(1, 1, 3, '0, "R4");
        // Dirty sharing: reads forwarded to owner (R3).
        do_req(0, 6, 3, '0, "R3");
        do_req(0, 0, 3, '0, "R3");
        // Upgrade by a sharer while another owns: forward plus one invalidation (R6, R7).
        do_req(2, 6, 3, '0, "R6");
        // Stale writeback from former owner ignored; read still forwarded (R10).
        do_req(3, 1, 3, 32'hAAAA_5555, "R10");
        do_req(0, 4, 3, '0, "R10");
        // Owner writeback then read from memory (R9).
        do_req(3, 6, 3, 32'h0000_CAFE, "R9");
        do_req(0, 7, 3, '0, "R9");
        // Exclusive read from memory, then exclusive read forwarded (R4, R5).
        do_req(1, 4, 3, '0, "R4");
        do_req(1, 2, 3, '0, "R5");
        // Grants: upgrade by the owner, upgrade of a memory-owned line (R6).
        do_req(2, 2, 3, '0, "R6");
        do_req(2, 0, 5, '0, "R6");
        // Full fan-out under backpressure, requests back to back (R8, R11, R12).
        bp_en = 1'b1;
        for (int n = 0; n < NODES; n++) do_req(0, n, 7, '0, "R2");
        do_req(1, 3, 7, '0, "R8");
        do_req(0, 5, 7, '0, "R11");
        do_req(3, 3, 7, 32'h1234_5678, "R12");
        do_req(0, 1, 7, '0, "R13");

        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #2;
        check(exp_q.size() == 0, "R11", "messages outstanding", exp_q.size(), 0);
        check(!msg_valid, "R11", "spurious message at end", msg_valid, 0);
        finish_up();
    end

endmodule